// File: doc/BRIEF.md
# AXI4-Lite Register Bank

This block is a small bank of read/write registers that sits behind an AXI4-Lite slave port with 32-bit address and data. Software on a bus master writes configuration words into it and reads them back. The contents of every register drive a flat output vector that neighbouring user logic samples directly. Each access is a single beat. The upstream interconnect has already routed the access to this block, so only the local register index is decoded and no address is ever refused.

The write side is a four-state machine. `WS_IDLE` accepts both address and data. If both handshakes occur in one cycle it goes straight to `WS_RESP`. If only the address arrives it goes to `WS_GOT_ADDR`, and if only the data arrives it goes to `WS_GOT_DATA`. `WS_GOT_ADDR` moves to `WS_RESP` on the data handshake, and `WS_GOT_DATA` moves to `WS_RESP` on the address handshake. The register update happens on the edge that enters `WS_RESP`. `WS_RESP` drives the response and returns to `WS_IDLE` once the master takes it. The read side has two states. `RS_IDLE` goes to `RS_RESP` on the address handshake and registers the selected word. `RS_RESP` returns to `RS_IDLE` when the master takes the data.

The parameter `IDX_W` sets the number of registers to 2^IDX_W. The parameter `ERR_MASK` marks the local indices that answer with a slave error. The defaults are eight registers, with indices 6 and 7 marked.

Top module: `axil_regbank`

## Requirements
- R1: While reset (active-low, sampled on the rising clock edge) is asserted and on the first cycle after it, awready, wready and arready are 1, bvalid and rvalid are 0, and every register reads as zero on regs_out.
- R2: When the write address and write data handshakes occur on the same edge, the addressed register takes the new value on that edge, and bvalid rises on the next cycle with bresp = 2'b00.
- R3: Write address and write data are accepted in either order. After only one of the two handshakes, that channel's ready stays low and the register is left unchanged until the other handshake completes the write.
- R4: Bit n of wstrb enables byte n, wdata[8n+7:8n], of the addressed register. A byte whose strobe bit is 0 keeps its old value, so wstrb = 4'b0000 changes nothing.
- R5: bvalid and bresp stay stable until bready is sampled high, and bvalid falls on the following cycle. awready and wready are 0 while bvalid is 1.
- R6: A read address handshake registers the selected word. rvalid rises on the next cycle and holds, with rdata and rresp stable, until rready is sampled high. arready is 0 while rvalid is 1.
- R7: Only address bits [IDX_W+1:2] select the register, where register k sits at byte offset 4*k. Bits [1:0] and all bits above IDX_W+1 are ignored, so aliased addresses reach the same register.
- R8: For a local index whose bit is set in ERR_MASK (indices 6 and 7 by default), a write leaves the register unchanged and returns bresp = 2'b10, and a read returns rdata = 0 with rresp = 2'b10. Other indices return 2'b00. The codes 2'b01 and 2'b11 are never driven.
- R9: A read handshake on the same edge as a completing write to the same register returns the value the register held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| awaddr | input | 32 | Write address |
| awvalid | input | 1 | Write address valid |
| awready | output | 1 | Write address accepted |
| wdata | input | 32 | Write data |
| wstrb | input | 4 | Byte enables for wdata |
| wvalid | input | 1 | Write data valid |
| wready | output | 1 | Write data accepted |
| bresp | output | 2 | Write response code |
| bvalid | output | 1 | Write response valid |
| bready | input | 1 | Master takes write response |
| araddr | input | 32 | Read address |
| arvalid | input | 1 | Read address valid |
| arready | output | 1 | Read address accepted |
| rdata | output | 32 | Read data |
| rresp | output | 2 | Read response code |
| rvalid | output | 1 | Read data valid |
| rready | input | 1 | Master takes read data |
| regs_out | output | 256 | All registers, register k at bits [32k+31:32k] |

## Verification
The hold properties on bvalid/bresp and rvalid/rdata/rresp assume a master that obeys the handshake rules. Once the master raises a valid, it keeps that valid and its payload steady until the matching ready is high at a clock edge. The master may raise bready or rready at any time, before or after the response appears. The stimulus tasks change inputs only on falling edges and keep each valid and its payload asserted until they see the ready high. They then drop the valid on the following falling edge. Response readies are held high until the response has been taken, either from the start or after a chosen delay, and this covers both orders.

// File: rtl/axil_rb_pkg.sv
package axil_rb_pkg;

    // Response codes on the read data and write response channels
    typedef enum logic [1:0] {
        RESP_OKAY   = 2'b00,
        RESP_SLVERR = 2'b10
    } resp_e;

    // Write side: which halves of a write have been captured
    typedef enum logic [1:0] {
        WS_IDLE,
        WS_GOT_ADDR,
        WS_GOT_DATA,
        WS_RESP
    } wr_state_e;

    // Read side: idle or presenting data
    typedef enum logic {
        RS_IDLE,
        RS_RESP
    } rd_state_e;

endpackage

// File: rtl/axil_rb_regfile.sv
module axil_rb_regfile #(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 3
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               wr_en,
    input  logic [IDX_W-1:0]                   wr_idx,
    input  logic [DATA_W-1:0]                  wr_data,
    input  logic [DATA_W/8-1:0]                wr_strb,
    input  logic [IDX_W-1:0]                   rd_idx,
    output logic [DATA_W-1:0]                  rd_val,
    output logic [(DATA_W<<IDX_W)-1:0]         regs_flat
);

    localparam int NUM_REGS = 1 << IDX_W;
    localparam int BYTES    = DATA_W / 8;

    // One flop group per byte lane of every register
    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
        for (genvar b = 0; b < BYTES; b++) begin : g_byte
            logic [7:0] byte_q;

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    byte_q <= '0;
                end else if (wr_en && (wr_idx == IDX_W'(r)) && wr_strb[b]) begin
                    byte_q <= wr_data[b*8 +: 8];
                end
            end

            assign regs_flat[r*DATA_W + b*8 +: 8] = byte_q;
        end
    end

    // Read selection sees the value before any write landing on this edge
    assign rd_val = regs_flat[rd_idx*DATA_W +: DATA_W];

endmodule

// File: rtl/axil_rb_wr_fsm.sv
module axil_rb_wr_fsm
    import axil_rb_pkg::*;
#(
    parameter int                    DATA_W   = 32,
    parameter int                    IDX_W    = 3,
    parameter logic [(1<<IDX_W)-1:0] ERR_MASK = '0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [IDX_W-1:0]     aw_idx,
    input  logic                 awvalid,
    output logic                 awready,
    input  logic [DATA_W-1:0]    wdata,
    input  logic [DATA_W/8-1:0]  wstrb,
    input  logic                 wvalid,
    output logic                 wready,
    output logic [1:0]           bresp,
    output logic                 bvalid,
    input  logic                 bready,
    output logic                 wr_en,
    output logic [IDX_W-1:0]     wr_idx,
    output logic [DATA_W-1:0]    wr_data,
    output logic [DATA_W/8-1:0]  wr_strb
);

    localparam int STRB_W = DATA_W / 8;

    wr_state_e            state_q, state_d;
    logic [IDX_W-1:0]     idx_q;
    logic [DATA_W-1:0]    data_q;
    logic [STRB_W-1:0]    strb_q;
    resp_e                bresp_q;
    logic                 aw_hs, w_hs, fire, sel_err;

    assign aw_hs = awvalid && awready;
    assign w_hs  = wvalid && wready;

    // Transitions
    always_comb begin
        state_d = state_q;
        fire    = 1'b0;
        unique case (state_q)
            WS_IDLE: begin
                if (aw_hs && w_hs) begin
                    state_d = WS_RESP;
                    fire    = 1'b1;
                end else if (aw_hs) begin
                    state_d = WS_GOT_ADDR;
                end else if (w_hs) begin
                    state_d = WS_GOT_DATA;
                end
            end
            WS_GOT_ADDR: begin
                if (w_hs) begin
                    state_d = WS_RESP;
                    fire    = 1'b1;
                end
            end
            WS_GOT_DATA: begin
                if (aw_hs) begin
                    state_d = WS_RESP;
                    fire    = 1'b1;
                end
            end
            WS_RESP: begin
                if (bready) state_d = WS_IDLE;
            end
            default: state_d = WS_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= WS_IDLE;
        else        state_q <= state_d;
    end

    // Outputs from state
    always_comb begin
        awready = 1'b0;
        wready  = 1'b0;
        bvalid  = 1'b0;
        unique case (state_q)
            WS_IDLE:     begin awready = 1'b1; wready = 1'b1; end
            WS_GOT_ADDR: wready  = 1'b1;
            WS_GOT_DATA: awready = 1'b1;
            WS_RESP:     bvalid  = 1'b1;
            default:     ;
        endcase
    end

    // Pick the captured half or the live half
    assign wr_idx  = (state_q == WS_GOT_ADDR) ? idx_q  : aw_idx;
    assign wr_data = (state_q == WS_GOT_DATA) ? data_q : wdata;
    assign wr_strb = (state_q == WS_GOT_DATA) ? strb_q : wstrb;
    assign sel_err = ERR_MASK[wr_idx];
    assign wr_en   = fire && !sel_err;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q   <= '0;
            data_q  <= '0;
            strb_q  <= '0;
            bresp_q <= RESP_OKAY;
        end else begin
            if (aw_hs) idx_q <= aw_idx;
            if (w_hs) begin
                data_q <= wdata;
                strb_q <= wstrb;
            end
            if (fire) bresp_q <= sel_err ? RESP_SLVERR : RESP_OKAY;
        end
    end

    assign bresp = bresp_q;

endmodule

// File: rtl/axil_rb_rd_fsm.sv
module axil_rb_rd_fsm
    import axil_rb_pkg::*;
#(
    parameter int                    DATA_W   = 32,
    parameter int                    IDX_W    = 3,
    parameter logic [(1<<IDX_W)-1:0] ERR_MASK = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [IDX_W-1:0]   ar_idx,
    input  logic               arvalid,
    output logic               arready,
    output logic [DATA_W-1:0]  rdata,
    output logic [1:0]         rresp,
    output logic               rvalid,
    input  logic               rready,
    output logic [IDX_W-1:0]   rd_idx,
    input  logic [DATA_W-1:0]  rd_val
);

    rd_state_e          state_q, state_d;
    logic [DATA_W-1:0]  rdata_q;
    resp_e              rresp_q;
    logic               ar_hs;

    assign ar_hs  = arvalid && arready;
    assign rd_idx = ar_idx;

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RS_IDLE: if (ar_hs)  state_d = RS_RESP;
            RS_RESP: if (rready) state_d = RS_IDLE;
            default: state_d = RS_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RS_IDLE;
        else        state_q <= state_d;
    end

    // Outputs from state
    always_comb begin
        arready = 1'b0;
        rvalid  = 1'b0;
        unique case (state_q)
            RS_IDLE: arready = 1'b1;
            RS_RESP: rvalid  = 1'b1;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
            rresp_q <= RESP_OKAY;
        end else if (ar_hs) begin
            rdata_q <= ERR_MASK[ar_idx] ? '0 : rd_val;
            rresp_q <= ERR_MASK[ar_idx] ? RESP_SLVERR : RESP_OKAY;
        end
    end

    assign rdata = rdata_q;
    assign rresp = rresp_q;

endmodule

// File: rtl/axil_regbank.sv
module axil_regbank #(
    parameter int                    ADDR_W   = 32,
    parameter int                    DATA_W   = 32,
    parameter int                    IDX_W    = 3,
    parameter logic [(1<<IDX_W)-1:0] ERR_MASK = 8'hC0
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [ADDR_W-1:0]           awaddr,
    input  logic                        awvalid,
    output logic                        awready,
    input  logic [DATA_W-1:0]           wdata,
    input  logic [DATA_W/8-1:0]         wstrb,
    input  logic                        wvalid,
    output logic                        wready,
    output logic [1:0]                  bresp,
    output logic                        bvalid,
    input  logic                        bready,
    input  logic [ADDR_W-1:0]           araddr,
    input  logic                        arvalid,
    output logic                        arready,
    output logic [DATA_W-1:0]           rdata,
    output logic [1:0]                  rresp,
    output logic                        rvalid,
    input  logic                        rready,
    output logic [(DATA_W<<IDX_W)-1:0]  regs_out
);

    localparam int LSB    = 2;
    localparam int MSB    = IDX_W + LSB - 1;
    localparam int STRB_W = DATA_W / 8;

    logic                 wr_en;
    logic [IDX_W-1:0]     wr_idx, rd_idx;
    logic [DATA_W-1:0]    wr_data, rd_val;
    logic [STRB_W-1:0]    wr_strb;

    axil_rb_wr_fsm #(.DATA_W(DATA_W), .IDX_W(IDX_W), .ERR_MASK(ERR_MASK)) wr_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .aw_idx  (awaddr[MSB:LSB]),
        .awvalid (awvalid),
        .awready (awready),
        .wdata   (wdata),
        .wstrb   (wstrb),
        .wvalid  (wvalid),
        .wready  (wready),
        .bresp   (bresp),
        .bvalid  (bvalid),
        .bready  (bready),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .wr_strb (wr_strb)
    );

    axil_rb_rd_fsm #(.DATA_W(DATA_W), .IDX_W(IDX_W), .ERR_MASK(ERR_MASK)) rd_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .ar_idx  (araddr[MSB:LSB]),
        .arvalid (arvalid),
        .arready (arready),
        .rdata   (rdata),
        .rresp   (rresp),
        .rvalid  (rvalid),
        .rready  (rready),
        .rd_idx  (rd_idx),
        .rd_val  (rd_val)
    );

    axil_rb_regfile #(.DATA_W(DATA_W), .IDX_W(IDX_W)) rf_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .wr_strb   (wr_strb),
        .rd_idx    (rd_idx),
        .rd_val    (rd_val),
        .regs_flat (regs_out)
    );

endmodule

// File: rtl/axil_rb_chk.sv
module axil_rb_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              awready,
    input logic              wready,
    input logic              bvalid,
    input logic              bready,
    input logic [1:0]        bresp,
    input logic              arready,
    input logic              rvalid,
    input logic              rready,
    input logic [DATA_W-1:0] rdata,
    input logic [1:0]        rresp,
    input logic              wr_en
);

    AST_WRITE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (bvalid && bresp == 2'b00)); // R2

    AST_BVALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (bvalid && !bready) |=> (bvalid && $stable(bresp))); // R5

    AST_BVALID_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (bvalid && bready) |=> !bvalid); // R5

    AST_WR_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        bvalid |-> (!awready && !wready)); // R5

    AST_RVALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rvalid && !rready) |=> (rvalid && $stable(rdata) && $stable(rresp))); // R6

    AST_RD_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |-> !arready); // R6

    AST_RESP_CODES: assert property (@(posedge clk) disable iff (!rst_n)
        ((!bvalid || !bresp[0]) && (!rvalid || !rresp[0]))); // R8

endmodule

bind axil_regbank axil_rb_chk #(.DATA_W(DATA_W)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .awready (awready),
    .wready  (wready),
    .bvalid  (bvalid),
    .bready  (bready),
    .bresp   (bresp),
    .arready (arready),
    .rvalid  (rvalid),
    .rready  (rready),
    .rdata   (rdata),
    .rresp   (rresp),
    .wr_en   (wr_en)
);

// File: tb/axil_regbank_tb_top.sv
module axil_regbank_tb_top;

    localparam int NREG = 8;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic         rst_n   = 1'b0;
    logic [31:0]  awaddr  = '0;
    logic         awvalid = 1'b0;
    logic [31:0]  wdata   = '0;
    logic [3:0]   wstrb   = '0;
    logic         wvalid  = 1'b0;
    logic         bready  = 1'b0;
    logic [31:0]  araddr  = '0;
    logic         arvalid = 1'b0;
    logic         rready  = 1'b0;
    logic         awready, wready, bvalid, arready, rvalid;
    logic [1:0]   bresp, rresp;
    logic [31:0]  rdata;
    logic [NREG*32-1:0] regs_out;

    int checks = 0;
    int errors = 0;

    axil_regbank dut_i (
        .clk(clk), .rst_n(rst_n),
        .awaddr(awaddr), .awvalid(awvalid), .awready(awready),
        .wdata(wdata), .wstrb(wstrb), .wvalid(wvalid), .wready(wready),
        .bresp(bresp), .bvalid(bvalid), .bready(bready),
        .araddr(araddr), .arvalid(arvalid), .arready(arready),
        .rdata(rdata), .rresp(rresp), .rvalid(rvalid), .rready(rready),
        .regs_out(regs_out)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit is_err(int idx);
        return (idx == 6) || (idx == 7);   // R8 default marked indices
    endfunction

    function automatic logic [31:0] reg_of(int k);
        return regs_out[k*32 +: 32];
    endfunction

    // Behavioural reference model, advanced on each rising edge
    logic [31:0] m_mem [NREG];
    bit          m_awh, m_wh, m_bv, m_rv;
    int          m_aidx;
    logic [31:0] m_wd, m_rd;
    logic [3:0]  m_ws;
    logic [1:0]  m_bresp, m_rresp;

    always @(posedge clk) begin : model_p
        bit aw_hs, w_hs, ar_hs;
        int idx;
        if (!rst_n) begin
            for (int k = 0; k < NREG; k++) m_mem[k] = '0;
            m_awh = 0; m_wh = 0; m_bv = 0; m_rv = 0;
            m_aidx = 0; m_wd = '0; m_ws = '0; m_rd = '0;
            m_bresp = 2'b00; m_rresp = 2'b00;
        end else begin
            aw_hs = awvalid && !m_awh && !m_bv;
            w_hs  = wvalid && !m_wh && !m_bv;
            ar_hs = arvalid && !m_rv;
            if (m_rv && rready) m_rv = 0;
            if (m_bv && bready) m_bv = 0;
            if (ar_hs) begin
                idx     = int'(araddr[4:2]);
                m_rd    = is_err(idx) ? 32'h0 : m_mem[idx];
                m_rresp = is_err(idx) ? 2'b10 : 2'b00;
                m_rv    = 1;
            end
            if (aw_hs) begin m_aidx = int'(awaddr[4:2]); m_awh = 1; end
            if (w_hs)  begin m_wd = wdata; m_ws = wstrb; m_wh = 1; end
            if (m_awh && m_wh) begin
                if (!is_err(m_aidx))
                    for (int b = 0; b < 4; b++)
                        if (m_ws[b]) m_mem[m_aidx][b*8 +: 8] = m_wd[b*8 +: 8];
                m_bresp = is_err(m_aidx) ? 2'b10 : 2'b00;
                m_bv = 1; m_awh = 0; m_wh = 0;
            end
        end
    end

    // Per-cycle comparison, away from the rising edge
    always @(negedge clk) begin
        if (rst_n) begin
            check("R3 awready", 32'(awready), 32'(!m_awh && !m_bv));
            check("R3 wready",  32'(wready),  32'(!m_wh && !m_bv));
            check("R5 bvalid",  32'(bvalid),  32'(m_bv));
            check("R5 bresp",   32'(bresp),   32'(m_bresp));
            check("R6 arready", 32'(arready), 32'(!m_rv));
            check("R6 rvalid",  32'(rvalid),  32'(m_rv));
            check("R6 rdata",   rdata,        m_rd);
            check("R6 rresp",   32'(rresp),   32'(m_rresp));
            for (int k = 0; k < NREG; k++)
                check("R4 regs_out", reg_of(k), m_mem[k]);
        end
    end

    // Channel drivers: change only on falling edges
    task automatic send_aw(input logic [31:0] a, input int dly);
        repeat (dly) @(negedge clk);
        awaddr = a; awvalid = 1'b1;
        while (!awready) @(negedge clk);
        @(negedge clk);
        awvalid = 1'b0;
    endtask

    task automatic send_w(input logic [31:0] d, input logic [3:0] s, input int dly);
        repeat (dly) @(negedge clk);
        wdata = d; wstrb = s; wvalid = 1'b1;
        while (!wready) @(negedge clk);
        @(negedge clk);
        wvalid = 1'b0;
    endtask

    task automatic get_b(input int dly, output logic [1:0] r);
        repeat (dly) @(negedge clk);
        bready = 1'b1;
        while (!bvalid) @(negedge clk);
        r = bresp;
        @(negedge clk);
        bready = 1'b0;
    endtask

    task automatic send_ar(input logic [31:0] a);
        araddr = a; arvalid = 1'b1;
        while (!arready) @(negedge clk);
        @(negedge clk);
        arvalid = 1'b0;
    endtask

    task automatic get_r(input int dly, output logic [31:0] d, output logic [1:0] r);
        repeat (dly) @(negedge clk);
        rready = 1'b1;
        while (!rvalid) @(negedge clk);
        d = rdata; r = rresp;
        @(negedge clk);
        rready = 1'b0;
    endtask

    // mode 0: same cycle, 1: address first, 2: data first
    task automatic axi_write(input logic [31:0] a, input logic [31:0] d, input logic [3:0] s,
                             input int mode, input int bdly, output logic [1:0] r);
        fork
            send_aw(a, (mode == 2) ? 2 : 0);
            send_w(d, s, (mode == 1) ? 2 : 0);
            get_b(bdly, r);
        join
    endtask

    task automatic axi_read(input logic [31:0] a, input int rdly,
                            output logic [31:0] d, output logic [1:0] r);
        fork
            send_ar(a);
            get_r(rdly, d, r);
        join
    endtask

    task automatic finish_run;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin : stim
        logic [1:0]  br, rr;
        logic [31:0] rd;

        repeat (3) @(negedge clk);
        // R1: reset values
        check("R1 awready", 32'(awready), 32'd1);
        check("R1 wready",  32'(wready),  32'd1);
        check("R1 arready", 32'(arready), 32'd1);
        check("R1 bvalid",  32'(bvalid),  32'd0);
        check("R1 rvalid",  32'(rvalid),  32'd0);
        for (int k = 0; k < NREG; k++) check("R1 regs_out", reg_of(k), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 arready after release", 32'(arready), 32'd1);

        // R2: address and data together
        axi_write(32'h0000_0000, 32'h1122_3344, 4'hF, 0, 0, br);
        check("R2 bresp", 32'(br), 32'h0);
        check("R2 reg0", reg_of(0), 32'h1122_3344);

        // R3: address first, then data first
        axi_write(32'h0000_0004, 32'hA5A5_A5A5, 4'hF, 1, 0, br);
        check("R3 reg1", reg_of(1), 32'hA5A5_A5A5);
        axi_write(32'h0000_0008, 32'h0BAD_BEEF, 4'hF, 2, 0, br);
        check("R3 reg2", reg_of(2), 32'h0BAD_BEEF);

        // R4: byte strobes
        axi_write(32'h0000_0000, 32'hFFFF_FFFF, 4'b0101, 0, 0, br);
        check("R4 reg0 strb0101", reg_of(0), 32'h11FF_33FF);
        axi_write(32'h0000_0000, 32'h0000_0000, 4'b0000, 0, 0, br);
        check("R4 reg0 strb0000", reg_of(0), 32'h11FF_33FF);
        axi_write(32'h0000_0000, 32'h0000_0000, 4'b1000, 1, 0, br);
        check("R4 reg0 strb1000", reg_of(0), 32'h00FF_33FF);

        // R5: late bready
        axi_write(32'h0000_0010, 32'hDEAD_0004, 4'hF, 0, 4, br);
        check("R5 bresp", 32'(br), 32'h0);
        check("R5 reg4", reg_of(4), 32'hDEAD_0004);

        // R6: late rready
        axi_read(32'h0000_0004, 3, rd, rr);
        check("R6 rdata", rd, 32'hA5A5_A5A5);
        check("R6 rresp", 32'(rr), 32'h0);

        // R7: aliased addresses reach register 3
        axi_write(32'hFFFF_FF0F, 32'hCAFE_F00D, 4'hF, 0, 0, br);
        check("R7 reg3", reg_of(3), 32'hCAFE_F00D);
        axi_read(32'h8000_000E, 0, rd, rr);
        check("R7 rdata", rd, 32'hCAFE_F00D);

        // R8: marked indices
        axi_write(32'h0000_0018, 32'hFFFF_FFFF, 4'hF, 0, 0, br);
        check("R8 bresp", 32'(br), 32'h2);
        check("R8 reg6", reg_of(6), 32'h0);
        axi_read(32'h0000_001C, 0, rd, rr);
        check("R8 rdata", rd, 32'h0);
        check("R8 rresp", 32'(rr), 32'h2);
        axi_read(32'h0000_0000, 0, rd, rr);
        check("R8 okay rresp", 32'(rr), 32'h0);

        // R9: read and write to reg2 on the same edge
        fork
            axi_write(32'h0000_0008, 32'h1234_5678, 4'hF, 0, 0, br);
            axi_read(32'h0000_0008, 0, rd, rr);
        join
        check("R9 old value", rd, 32'h0BAD_BEEF);
        axi_read(32'h0000_0008, 0, rd, rr);
        check("R9 new value", rd, 32'h1234_5678);

        // Mixed traffic, checked by the model every cycle
        for (int i = 0; i < 80; i++) begin
            logic [31:0] wa, ra, dd;
            wa = {$urandom_range(0, 255), 3'($urandom_range(0, 7)), 2'($urandom_range(0, 3))};
            ra = {$urandom_range(0, 255), 3'($urandom_range(0, 7)), 2'($urandom_range(0, 3))};
            dd = $urandom;
            fork
                axi_write(wa, dd, 4'($urandom_range(0, 15)), $urandom_range(0, 2),
                          $urandom_range(0, 3), br);
                if (i % 2 == 0) axi_read(ra, $urandom_range(0, 3), rd, rr);
            join
        end

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule